// File: doc/BRIEF.md
# Packed-BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar as packed-BCD bytes: seconds, minutes, hours, date, month, a two-digit year and a three-bit weekday. A clock-enable at 32768 Hz feeds a binary prescaler whose terminal count produces a once-per-second tick. Each tick advances the seconds, and a cascade of carries moves the time up through minutes, hours, date, month and year. The weekday steps at every midnight on its own, with no link to the date value.

The hour byte carries its own format. One bit selects 24-hour or 12-hour counting, and in 12-hour mode a second bit is the PM flag. Software sets the time one byte at a time through a parallel write port. A separate load strobe then clears the prescaler, so the first tick comes a full second after the load. The prescaler count is brought out so that other logic can use its intermediate divided rates.

Top module: `rtc_calendar`

## Requirements
- R1: After reset every time byte, the weekday and the prescaler count read zero. A zero hour byte is 12-hour mode with the PM flag clear.
- R2: The prescaler counts only on cycles with `tick32k` high. `secTick` is high exactly when the count is all ones, `tick32k` is high and `loadStrobe` is low, which is once every 2^PRESC_BITS enables.
- R3: Seconds and minutes count 00 to 59 in BCD. On the tick at second 59, seconds go to 00 and minutes advance. At minute 59 the hour advances as well.
- R4: With hour bit 7 at 1 (24-hour mode), hour bits 5:0 count 00 to 23 in BCD. 23 wraps to 00 and advances the day.
- R5: With hour bit 7 at 0 (12-hour mode), hour bits 4:0 follow the order 12, 01, ..., 11. Bit 5 (PM) inverts on the step from 11 to 12. The step from 11 PM to 12 AM advances the day.
- R6: At the end of a day the date goes to 01 and the month advances when the date equals the month's length. Months 04, 06, 09 and 11 have 30 days, months 01, 03, 05, 07, 08, 10 and 12 have 31, and any other date steps up by one in BCD.
- R7: Month 02 has 29 days when the BCD year, read as a number, divides by 4 (year 00 included), and 28 days otherwise.
- R8: At the end of day 31 of month 12, the month goes to 01 and the year advances in BCD. Year 99 wraps to 00.
- R9: The weekday counts 0 to 6 and back to 0, one step at each day advance, whatever the date or month.
- R10: With `wrEn` high, `wrAddr` picks the byte to replace: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday. Address 7 changes nothing. Bits a field does not use are stored as zero; the weekday keeps bits 2:0. A write cycle takes precedence over the tick, and that tick's advance is dropped for every field.
- R11: `loadStrobe` clears the prescaler and blocks the tick in that cycle, so the next tick comes 2^PRESC_BITS enables later. `prescTaps` shows the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick32k | input | 1 | 32768 Hz clock enable for the prescaler |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 3 | Field select for the write |
| wrData | input | 8 | Byte to be written |
| loadStrobe | input | 1 | End of a time load; restarts the prescaler |
| secOut | output | 8 | BCD seconds |
| minOut | output | 8 | BCD minutes |
| hourOut | output | 8 | Mode bit 7, PM bit 5, BCD hours |
| dateOut | output | 8 | BCD day of month |
| monthOut | output | 8 | BCD month |
| yearOut | output | 8 | BCD two-digit year |
| dowOut | output | 3 | Weekday 0 to 6 |
| secTick | output | 1 | One-cycle pulse per second |
| prescTaps | output | PRESC_BITS | Prescaler count |

## Verification
The once-per-second tick can land in the same cycle as a byte write or as the load strobe. The bench waits at a falling edge until the tick is showing and then drives the write or the strobe into that same cycle. On a write, the written seconds value must appear with no increment and the minutes must not move. On a load, the time must stay put and the next tick must come a full prescaler period later, not early.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 3;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_DOW  = 6;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] wrSel;
    logic [7:0]            wrByte;
  } calStrobe_t;

  // Next packed-BCD value (no wrap).
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year divisible by 4: 10*t+u and 2*t+u agree modulo 4.
  function automatic logic leapYear(input logic [7:0] y);
    logic [5:0] s;
    s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
    leapYear = (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] monthLen(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      monthLen = leapYear(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthLen = 8'h30;
      default:                    monthLen = 8'h31;
    endcase
  endfunction

  // Stored bits per field; others read zero.
  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      F_SEC, F_MIN: fieldMask = 8'h7F;
      F_HOUR:       fieldMask = 8'hBF;
      F_DATE:       fieldMask = 8'h3F;
      F_MON:        fieldMask = 8'h1F;
      F_YEAR:       fieldMask = 8'hFF;
      default:      fieldMask = 8'h07;
    endcase
  endfunction

  // Hour step in either format.
  function automatic logic [7:0] hourStep(input logic [7:0] h);
    logic [7:0] t;
    if (h[7]) begin
      if (h[5:0] == 6'h23) hourStep = 8'h80;
      else begin
        t = bcdInc({2'b00, h[5:0]});
        hourStep = {2'b10, t[5:0]};
      end
    end else begin
      if (h[4:0] == 5'h12)      hourStep = {2'b00, h[5], 5'h01};
      else if (h[4:0] == 5'h11) hourStep = {2'b00, ~h[5], 5'h12};
      else begin
        t = bcdInc({3'b000, h[4:0]});
        hourStep = {2'b00, h[5], t[4:0]};
      end
    end
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int PRESC_BITS = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick32k,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [7:0]            wrData,
  input  logic                  loadStrobe,
  output calStrobe_t            strobe,
  output logic                  secTick,
  output logic [PRESC_BITS-1:0] prescTaps
);

  logic [PRESC_BITS-1:0] prescQ;
  logic [NUM_FIELDS-1:0] wrSel;
  logic                  rawTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prescQ <= '0;
    else if (loadStrobe) prescQ <= '0;
    else if (tick32k)    prescQ <= prescQ + 1'b1;
  end

  assign rawTick = tick32k && (&prescQ) && !loadStrobe;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_sel
    assign wrSel[g] = wrEn && (wrAddr == ADDR_W'(g));
  end

  // A byte write cancels the advance for that tick.
  assign strobe    = {rawTick && !wrEn, wrSel, wrData};
  assign secTick   = rawTick;
  assign prescTaps = prescQ;

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  calStrobe_t                  strobe,
  output logic [NUM_FIELDS-1:0][7:0]  fields
);

  logic [NUM_FIELDS-1:0][7:0] fieldQ;
  logic [NUM_FIELDS-1:0][7:0] nextVal;
  logic [NUM_FIELDS-1:0]      incEn;
  logic secEnd, minEnd, dayEnd, dateEnd, monEnd;

  always_comb begin
    secEnd  = (fieldQ[F_SEC] == 8'h59);
    minEnd  = (fieldQ[F_MIN] == 8'h59);
    dayEnd  = fieldQ[F_HOUR][7] ? (fieldQ[F_HOUR][5:0] == 6'h23)
                                : (fieldQ[F_HOUR][5] && fieldQ[F_HOUR][4:0] == 5'h11);
    dateEnd = (fieldQ[F_DATE] == monthLen(fieldQ[F_MON], fieldQ[F_YEAR]));
    monEnd  = (fieldQ[F_MON] == 8'h12);

    incEn[F_SEC]  = strobe.advance;
    incEn[F_MIN]  = incEn[F_SEC] && secEnd;
    incEn[F_HOUR] = incEn[F_MIN] && minEnd;
    incEn[F_DATE] = incEn[F_HOUR] && dayEnd;
    incEn[F_DOW]  = incEn[F_DATE];
    incEn[F_MON]  = incEn[F_DATE] && dateEnd;
    incEn[F_YEAR] = incEn[F_MON] && monEnd;

    nextVal[F_SEC]  = secEnd  ? 8'h00 : bcdInc(fieldQ[F_SEC]);
    nextVal[F_MIN]  = minEnd  ? 8'h00 : bcdInc(fieldQ[F_MIN]);
    nextVal[F_HOUR] = hourStep(fieldQ[F_HOUR]);
    nextVal[F_DATE] = dateEnd ? 8'h01 : bcdInc(fieldQ[F_DATE]);
    nextVal[F_MON]  = monEnd  ? 8'h01 : bcdInc(fieldQ[F_MON]);
    nextVal[F_YEAR] = (fieldQ[F_YEAR] == 8'h99) ? 8'h00 : bcdInc(fieldQ[F_YEAR]);
    nextVal[F_DOW]  = (fieldQ[F_DOW][2:0] == 3'd6) ? 8'h00
                                                   : {5'b0, fieldQ[F_DOW][2:0] + 3'd1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fieldQ <= '0;
    else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (strobe.wrSel[i])  fieldQ[i] <= strobe.wrByte & fieldMask(i);
        else if (incEn[i])    fieldQ[i] <= nextVal[i];
      end
    end
  end

  assign fields = fieldQ;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESC_BITS = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick32k,
  input  logic                  wrEn,
  input  logic [2:0]            wrAddr,
  input  logic [7:0]            wrData,
  input  logic                  loadStrobe,
  output logic [7:0]            secOut,
  output logic [7:0]            minOut,
  output logic [7:0]            hourOut,
  output logic [7:0]            dateOut,
  output logic [7:0]            monthOut,
  output logic [7:0]            yearOut,
  output logic [2:0]            dowOut,
  output logic                  secTick,
  output logic [PRESC_BITS-1:0] prescTaps
);

  calStrobe_t                 strobe;
  logic [NUM_FIELDS-1:0][7:0] fields;

  rtc_cal_ctrl #(.PRESC_BITS(PRESC_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick32k    (tick32k),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .loadStrobe (loadStrobe),
    .strobe     (strobe),
    .secTick    (secTick),
    .prescTaps  (prescTaps)
  );

  rtc_cal_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .fields (fields)
  );

  assign secOut   = fields[F_SEC];
  assign minOut   = fields[F_MIN];
  assign hourOut  = fields[F_HOUR];
  assign dateOut  = fields[F_DATE];
  assign monthOut = fields[F_MON];
  assign yearOut  = fields[F_YEAR];
  assign dowOut   = fields[F_DOW][2:0];

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
  parameter int PRESC_BITS = 15
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  tick32k,
  input logic                  wrEn,
  input logic [2:0]            wrAddr,
  input logic [7:0]            wrData,
  input logic                  loadStrobe,
  input logic [7:0]            secOut,
  input logic [7:0]            minOut,
  input logic [7:0]            hourOut,
  input logic [7:0]            dateOut,
  input logic [7:0]            monthOut,
  input logic [7:0]            yearOut,
  input logic [2:0]            dowOut,
  input logic                  secTick,
  input logic [PRESC_BITS-1:0] prescTaps
);

  a_r2_tick_at_terminal: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (tick32k && (&prescTaps)));

  a_r11_load_restart: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> (prescTaps == '0));

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !wrEn && secOut == 8'h59) |=> (secOut == 8'h00 && !$stable(minOut)));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd0) |=> (secOut == ($past(wrData) & 8'h7F)));

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !wrEn) |=> ($stable(secOut) && $stable(minOut) && $stable(hourOut)
                             && $stable(dateOut) && $stable(monthOut)
                             && $stable(yearOut) && $stable(dowOut)));

  a_r9_dow_follows_day: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(dowOut) == $stable(dateOut)));

endmodule

bind rtc_calendar rtc_cal_checker #(.PRESC_BITS(PRESC_BITS)) u_chk (.*);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;

  localparam int PB = 4;
  localparam int PERIOD = 1 << PB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick32k = 1'b1;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic          loadStrobe = 1'b0;
  logic [7:0]    secOut, minOut, hourOut, dateOut, monthOut, yearOut;
  logic [2:0]    dowOut;
  logic          secTick;
  logic [PB-1:0] prescTaps;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.PRESC_BITS(PB)) i_rtc_calendar (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .loadStrobe(loadStrobe), .secOut(secOut), .minOut(minOut),
    .hourOut(hourOut), .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut),
    .dowOut(dowOut), .secTick(secTick), .prescTaps(prescTaps)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, m, h, d, mo, y, input logic [2:0] dw);
    writeReg(3'd0, s); writeReg(3'd1, m); writeReg(3'd2, h);
    writeReg(3'd3, d); writeReg(3'd4, mo); writeReg(3'd5, y);
    writeReg(3'd6, {5'b0, dw});
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic stepSeconds(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!secTick) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 sec", secOut, 8'h00);   check("R1 min", minOut, 8'h00);
    check("R1 hour", hourOut, 8'h00); check("R1 date", dateOut, 8'h00);
    check("R1 month", monthOut, 8'h00); check("R1 year", yearOut, 8'h00);
    check("R1 dow", dowOut, 3'd0);    check("R1 taps", prescTaps, '0);
  endtask

  task automatic testPrescaler();
    logic [PB-1:0] held;
    int early = 0;
    @(negedge clk);
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    check("R11 taps cleared", prescTaps, '0);
    for (int k = 2; k <= PERIOD; k++) begin
      @(negedge clk);
      if (k == 6) check("R11 taps running", prescTaps, 4'd5);
      if (k < PERIOD && secTick) early++;
    end
    check("R2 no early tick", early, 0);
    check("R2 tick after full period", secTick, 1'b1);
    tick32k = 1'b0;
    held = prescTaps;
    repeat (5) @(negedge clk);
    check("R2 frozen without enable", prescTaps, held);
    check("R2 no tick without enable", secTick, 1'b0);
    tick32k = 1'b1;
  endtask

  task automatic testSecMin();
    setTime(8'h58, 8'h20, 8'h85, 8'h10, 8'h03, 8'h21, 3'd1);
    stepSeconds(1);
    check("R3 sec bcd step", secOut, 8'h59);
    stepSeconds(1);
    check("R3 sec wrap", secOut, 8'h00);
    check("R3 min carry", minOut, 8'h21);
    setTime(8'h59, 8'h59, 8'h85, 8'h10, 8'h03, 8'h21, 3'd1);
    stepSeconds(1);
    check("R3 min wrap", minOut, 8'h00);
    check("R3 hour carry", hourOut, 8'h86);
  endtask

  task automatic testHour24();
    setTime(8'h59, 8'h59, 8'hA3, 8'h15, 8'h06, 8'h24, 3'd6);
    stepSeconds(1);
    check("R4 hour 23 to 00", hourOut, 8'h80);
    check("R4 day advance", dateOut, 8'h16);
    check("R9 dow 6 to 0", dowOut, 3'd0);
  endtask

  task automatic testHour12();
    setTime(8'h59, 8'h59, 8'h11, 8'h10, 8'h05, 8'h22, 3'd2);
    stepSeconds(1);
    check("R5 11AM to 12PM", hourOut, 8'h32);
    check("R5 no day at noon", dateOut, 8'h10);
    setTime(8'h59, 8'h59, 8'h32, 8'h10, 8'h05, 8'h22, 3'd2);
    stepSeconds(1);
    check("R5 12PM to 01PM", hourOut, 8'h21);
    setTime(8'h59, 8'h59, 8'h31, 8'h10, 8'h05, 8'h22, 3'd2);
    stepSeconds(1);
    check("R5 11PM to 12AM", hourOut, 8'h12);
    check("R5 midnight day", dateOut, 8'h11);
    check("R9 dow step", dowOut, 3'd3);
  endtask

  task automatic testMonths();
    setTime(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h22, 3'd0);
    stepSeconds(1);
    check("R6 30-day month date", dateOut, 8'h01);
    check("R6 30-day month next", monthOut, 8'h05);
    setTime(8'h59, 8'h59, 8'hA3, 8'h30, 8'h05, 8'h22, 3'd0);
    stepSeconds(1);
    check("R6 31-day month", dateOut, 8'h31);
  endtask

  task automatic testLeap();
    setTime(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 3'd0);
    stepSeconds(1);
    check("R7 leap 24", dateOut, 8'h29);
    setTime(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h00, 3'd0);
    stepSeconds(1);
    check("R7 leap 00", dateOut, 8'h29);
    setTime(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 3'd0);
    stepSeconds(1);
    check("R7 common 23 date", dateOut, 8'h01);
    check("R7 common 23 month", monthOut, 8'h03);
    setTime(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h12, 3'd0);
    stepSeconds(1);
    check("R7 leap end", monthOut, 8'h03);
  endtask

  task automatic testYear();
    setTime(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 3'd3);
    stepSeconds(1);
    check("R8 year 99 wrap", yearOut, 8'h00);
    check("R8 month to 01", monthOut, 8'h01);
    check("R8 date to 01", dateOut, 8'h01);
    check("R9 dow independent", dowOut, 3'd4);
    setTime(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h19, 3'd0);
    stepSeconds(1);
    check("R8 year bcd step", yearOut, 8'h20);
  endtask

  task automatic testCollisions();
    logic [7:0] s0, m0, h0, d0, mo0, y0;
    logic [2:0] w0;
    int early = 0;
    // Write in the tick cycle.
    setTime(8'h10, 8'h20, 8'h80, 8'h01, 8'h01, 8'h20, 3'd0);
    while (!secTick) @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h42;
    @(negedge clk);
    wrEn = 1'b0;
    check("R10 write beats tick", secOut, 8'h42);
    check("R10 no minute move", minOut, 8'h20);
    // Load in the tick cycle.
    while (!secTick) @(negedge clk);
    s0 = secOut;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    check("R11 load blocks tick", secOut, s0);
    for (int k = 2; k <= PERIOD; k++) begin
      @(negedge clk);
      if (k < PERIOD && secTick) early++;
    end
    check("R11 no early tick after load", early, 0);
    check("R11 tick one period after load", secTick, 1'b1);
    // Address 7 writes nothing.
    @(negedge clk);
    s0 = secOut; m0 = minOut; h0 = hourOut; d0 = dateOut;
    mo0 = monthOut; y0 = yearOut; w0 = dowOut;
    wrEn = 1'b1; wrAddr = 3'd7; wrData = 8'hFF;
    @(negedge clk);
    wrEn = 1'b0;
    check("R10 addr7 ignored", {s0, m0, h0, d0}, {secOut, minOut, hourOut, dateOut});
    check("R10 addr7 ignored hi", {mo0, y0, 5'b0, w0}, {monthOut, yearOut, 5'b0, dowOut});
    writeReg(3'd6, 8'hFD);
    check("R10 dow masked", dowOut, 3'd5);
  endtask

  initial begin
    #(20 * 150000);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPrescaler();
    testSecMin();
    testHour24();
    testHour12();
    testMonths();
    testLeap();
    testYear();
    testCollisions();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule